// File: doc/BRIEF.md
# Configuration Address/Data Port Bridge

This block lets a host reach PCI configuration space through two small register windows. The first window holds a 32-bit configuration address register. The register selects a bus, a device/function pair and a register offset, and its top bit enables forwarding. The second window is a data window. A read or write there becomes a single request on a downstream configuration interface. That request carries the bus number, the device/function, the register offset, the byte count and the write data, and it returns read data.

Before it forwards an access, the bridge asks the downstream side whether the addressed device exists. It does this through a combinational probe driven from the address register. The low two bits of the data-window offset are merged into the register offset. The byte count is clipped so that no request runs past the 256-byte space. While a request is outstanding, the host is held busy. Only one request can be in flight at a time.

Top module: `cfgb_top`

## Requirements
- R1: The address register loads `hst_wdata` only on an address-window write (`hst_sel`=0) with `hst_off`=0 and `hst_len`=4. An address-window write at any other offset or length leaves the register unchanged.
- R2: An address-window read completes with `hst_rdata` equal to the current 32-bit address register.
- R3: A forwarded request carries bus = register bits 23:16 and device/function = register bits 15:8. The same two fields drive `probe_bus` and `probe_devfn`.
- R4: While register bit 31 is 0, a data-window write (`hst_sel`=1, `hst_we`=1) raises no `dn_valid`.
- R5: While bit 31 is 0, a data-window read raises no `dn_valid` and returns all ones limited to the access width. Length 1 returns 0x000000FF, length 2 returns 0x0000FFFF and length 4 returns 0xFFFFFFFF.
- R6: The downstream register offset is (register bits 7:0) bitwise-OR `hst_off`, taken modulo 256. It is an OR, not a sum.
- R7: `dn_len` equals the smaller of `hst_len` and (256 − offset).
- R8: When `dev_present` is 0 at the time of acceptance, a data read returns all ones limited to the access width, and a data write is dropped. Neither one raises `dn_valid`.
- R9: `dn_valid` is high for exactly one cycle per forwarded access, starting the cycle after acceptance. `hst_busy` stays high until `dn_rvalid` is seen. `hst_done` pulses the cycle after `dn_rvalid`, and `hst_rdata` then equals `dn_rdata`. Any access that is not forwarded completes with `hst_done` one cycle after acceptance.
- R10: After reset the address register reads 0, the data window is disabled, and `dn_valid`, `hst_busy` and `hst_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_req | input | 1 | Host access strobe, accepted when not busy |
| hst_we | input | 1 | 1 = write, 0 = read |
| hst_sel | input | 1 | 0 = address window, 1 = data window |
| hst_off | input | 2 | Byte offset within the window |
| hst_len | input | 3 | Access length in bytes (1, 2 or 4) |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, valid with hst_done |
| hst_busy | output | 1 | Access in progress |
| hst_done | output | 1 | One-cycle completion pulse |
| probe_bus | output | 8 | Bus number for the presence lookup |
| probe_devfn | output | 8 | Device/function for the presence lookup |
| dev_present | input | 1 | Addressed device exists |
| dn_valid | output | 1 | One-cycle downstream request strobe |
| dn_we | output | 1 | Downstream write flag |
| dn_bus | output | 8 | Downstream bus number |
| dn_devfn | output | 8 | Downstream device/function |
| dn_reg | output | 8 | Downstream register offset |
| dn_len | output | 3 | Downstream byte count after clipping |
| dn_wdata | output | 32 | Downstream write data |
| dn_rvalid | input | 1 | Downstream response strobe |
| dn_rdata | input | 32 | Downstream read data |

## Verification
An access that is accepted on a clock edge shows its effect at the next edge. That effect is one of three: a written address register, a completion on `hst_done`, or the `dn_valid` strobe. Completion of a forwarded access comes one edge after the `dn_rvalid` that the bench model drives. The bench drives and samples on falling edges. It scans each falling edge after acceptance for `dn_valid` and `hst_done`, and it counts the cycles in which the strobe is high. Both the timing and the single-cycle width of the strobe are therefore checked at the cycle where they fall due, not just eventually. The bench model answers a request two cycles after its strobe, which leaves a window in which the bench checks that `hst_busy` is held.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
  localparam int CFG_W   = 32;
  localparam int FIELD_W = 8;
  localparam int EN_BIT  = 31;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_WAIT = 2'd1,
    SQ_DONE = 2'd2
  } sq_state_e;
endpackage

// File: rtl/cfgb_addr_reg.sv
module cfgb_addr_reg
  import cfgb_pkg::*;
#(
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             hst_we,
  input  logic             hst_sel,
  input  logic [1:0]       hst_off,
  input  logic [LEN_W-1:0] hst_len,
  input  logic [CFG_W-1:0] hst_wdata,
  output logic [CFG_W-1:0] cfg_q
);
  localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(CFG_W / 8);

  logic             load_en;
  logic [CFG_W-1:0] cfg_d;

  always_comb begin
    load_en = accept && hst_we && !hst_sel && (hst_off == 2'd0) && (hst_len == FULL_LEN);
    cfg_d   = load_en ? hst_wdata : cfg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  // R1: without a qualifying full-width write at offset 0 the register holds
  a_r1_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && hst_we && !hst_sel && hst_off == 2'd0 && hst_len == FULL_LEN)
      |=> $stable(cfg_q));
endmodule

// File: rtl/cfgb_target.sv
module cfgb_target
  import cfgb_pkg::*;
#(
  parameter int SPACE = 256,
  parameter int LEN_W = 3
) (
  input  logic [CFG_W-1:0]   cfg_q,
  input  logic [1:0]         win_off,
  input  logic [LEN_W-1:0]   req_len,
  output logic               enabled,
  output logic [FIELD_W-1:0] t_bus,
  output logic [FIELD_W-1:0] t_devfn,
  output logic [$clog2(SPACE)-1:0] t_reg,
  output logic [LEN_W-1:0]   t_len
);
  localparam int OFF_W = $clog2(SPACE);

  logic [CFG_W-1:0] merged;
  int               room;

  always_comb begin
    merged  = cfg_q | {{(CFG_W-2){1'b0}}, win_off};
    enabled = cfg_q[EN_BIT];
    t_bus   = cfg_q[2*FIELD_W +: FIELD_W];
    t_devfn = cfg_q[FIELD_W +: FIELD_W];
    t_reg   = merged[OFF_W-1:0];
    room    = SPACE - int'(t_reg);
    if (int'(req_len) > room) t_len = LEN_W'(room);
    else                      t_len = req_len;
  end
endmodule

// File: rtl/cfgb_seq.sv
module cfgb_seq
  import cfgb_pkg::*;
#(
  parameter int SPACE = 256,
  parameter int LEN_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hst_req,
  input  logic               hst_we,
  input  logic               hst_sel,
  input  logic [LEN_W-1:0]   hst_len,
  input  logic [CFG_W-1:0]   hst_wdata,
  input  logic [CFG_W-1:0]   cfg_q,
  input  logic               enabled,
  input  logic [FIELD_W-1:0] t_bus,
  input  logic [FIELD_W-1:0] t_devfn,
  input  logic [$clog2(SPACE)-1:0] t_reg,
  input  logic [LEN_W-1:0]   t_len,
  input  logic               dev_present,
  input  logic               dn_rvalid,
  input  logic [CFG_W-1:0]   dn_rdata,
  output logic               accept,
  output logic               hst_busy,
  output logic               hst_done,
  output logic [CFG_W-1:0]   hst_rdata,
  output logic               dn_valid,
  output logic               dn_we,
  output logic [FIELD_W-1:0] dn_bus,
  output logic [FIELD_W-1:0] dn_devfn,
  output logic [$clog2(SPACE)-1:0] dn_reg,
  output logic [LEN_W-1:0]   dn_len,
  output logic [CFG_W-1:0]   dn_wdata
);
  localparam int OFF_W = $clog2(SPACE);

  sq_state_e        st_q, st_d;
  logic             dv_d, load_dn;
  logic [CFG_W-1:0] rd_q, rd_d;
  logic [CFG_W-1:0] ones_mask;

  always_comb begin
    ones_mask = '1;
    if (int'(hst_len) < CFG_W / 8)
      ones_mask = (CFG_W'(1) << (8 * int'(hst_len))) - CFG_W'(1);
  end

  always_comb begin
    st_d    = st_q;
    dv_d    = 1'b0;
    load_dn = 1'b0;
    rd_d    = rd_q;
    accept  = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (hst_req) begin
          accept = 1'b1;
          if (!hst_sel) begin
            st_d = SQ_DONE;
            rd_d = cfg_q;
          end else if (!enabled || !dev_present) begin
            st_d = SQ_DONE;
            rd_d = ones_mask;
          end else begin
            st_d    = SQ_WAIT;
            dv_d    = 1'b1;
            load_dn = 1'b1;
          end
        end
      end
      SQ_WAIT: begin
        if (dn_rvalid) begin
          st_d = SQ_DONE;
          rd_d = dn_rdata;
        end
      end
      SQ_DONE: st_d = SQ_IDLE;
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= SQ_IDLE;
      dn_valid <= 1'b0;
      rd_q     <= '0;
    end else begin
      st_q     <= st_d;
      dn_valid <= dv_d;
      rd_q     <= rd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dn_we    <= 1'b0;
      dn_bus   <= '0;
      dn_devfn <= '0;
      dn_reg   <= '0;
      dn_len   <= '0;
      dn_wdata <= '0;
    end else if (load_dn) begin
      dn_we    <= hst_we;
      dn_bus   <= t_bus;
      dn_devfn <= t_devfn;
      dn_reg   <= t_reg;
      dn_len   <= t_len;
      dn_wdata <= hst_wdata;
    end
  end

  assign hst_busy  = (st_q != SQ_IDLE);
  assign hst_done  = (st_q == SQ_DONE);
  assign hst_rdata = rd_q;

  // R4 / R5: a disabled data access raises no strobe
  a_r4_gate_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_IDLE && hst_req && hst_sel && !enabled) |=> !dn_valid);
  // R8: an absent device gets no strobe
  a_r8_absent_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_IDLE && hst_req && hst_sel && !dev_present) |=> !dn_valid);
  // R9: the strobe lasts one cycle and the host is held busy
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |=> !dn_valid);
  a_r9_busy_held: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> (hst_busy && !hst_done));
  // R7: a forwarded request never runs past the end of the space
  a_r7_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> ((int'(dn_reg) + int'(dn_len)) <= SPACE));
  // R9: completion needs a response while waiting
  a_r9_done_after_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_WAIT && !dn_rvalid) |=> !hst_done);
endmodule

// File: rtl/cfgb_top.sv
module cfgb_top
  import cfgb_pkg::*;
#(
  parameter int SPACE = 256,
  parameter int LEN_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hst_req,
  input  logic               hst_we,
  input  logic               hst_sel,
  input  logic [1:0]         hst_off,
  input  logic [LEN_W-1:0]   hst_len,
  input  logic [31:0]        hst_wdata,
  output logic [31:0]        hst_rdata,
  output logic               hst_busy,
  output logic               hst_done,
  output logic [7:0]         probe_bus,
  output logic [7:0]         probe_devfn,
  input  logic               dev_present,
  output logic               dn_valid,
  output logic               dn_we,
  output logic [7:0]         dn_bus,
  output logic [7:0]         dn_devfn,
  output logic [$clog2(SPACE)-1:0] dn_reg,
  output logic [LEN_W-1:0]   dn_len,
  output logic [31:0]        dn_wdata,
  input  logic               dn_rvalid,
  input  logic [31:0]        dn_rdata
);
  localparam int OFF_W = $clog2(SPACE);

  logic               accept;
  logic [CFG_W-1:0]   cfg_q;
  logic               enabled;
  logic [FIELD_W-1:0] t_bus, t_devfn;
  logic [OFF_W-1:0]   t_reg;
  logic [LEN_W-1:0]   t_len;

  cfgb_addr_reg #(.LEN_W(LEN_W)) u_areg (
    .clk(clk), .rst_n(rst_n), .accept(accept), .hst_we(hst_we),
    .hst_sel(hst_sel), .hst_off(hst_off), .hst_len(hst_len),
    .hst_wdata(hst_wdata), .cfg_q(cfg_q)
  );

  cfgb_target #(.SPACE(SPACE), .LEN_W(LEN_W)) u_tgt (
    .cfg_q(cfg_q), .win_off(hst_off), .req_len(hst_len), .enabled(enabled),
    .t_bus(t_bus), .t_devfn(t_devfn), .t_reg(t_reg), .t_len(t_len)
  );

  cfgb_seq #(.SPACE(SPACE), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .hst_req(hst_req), .hst_we(hst_we),
    .hst_sel(hst_sel), .hst_len(hst_len), .hst_wdata(hst_wdata),
    .cfg_q(cfg_q), .enabled(enabled), .t_bus(t_bus), .t_devfn(t_devfn),
    .t_reg(t_reg), .t_len(t_len), .dev_present(dev_present),
    .dn_rvalid(dn_rvalid), .dn_rdata(dn_rdata), .accept(accept),
    .hst_busy(hst_busy), .hst_done(hst_done), .hst_rdata(hst_rdata),
    .dn_valid(dn_valid), .dn_we(dn_we), .dn_bus(dn_bus),
    .dn_devfn(dn_devfn), .dn_reg(dn_reg), .dn_len(dn_len),
    .dn_wdata(dn_wdata)
  );

  assign probe_bus   = t_bus;
  assign probe_devfn = t_devfn;
endmodule

// File: tb/cfgb_top_tb_top.sv
module cfgb_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_req = 1'b0, hst_we = 1'b0, hst_sel = 1'b0;
  logic [1:0]  hst_off = '0;
  logic [2:0]  hst_len = '0;
  logic [31:0] hst_wdata = '0;
  logic [31:0] hst_rdata;
  logic        hst_busy, hst_done;
  logic [7:0]  probe_bus, probe_devfn;
  logic        dev_present = 1'b1;
  logic        dn_valid, dn_we;
  logic [7:0]  dn_bus, dn_devfn, dn_reg;
  logic [2:0]  dn_len;
  logic [31:0] dn_wdata;
  logic        dn_rvalid = 1'b0;
  logic [31:0] dn_rdata = '0;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cfgb_top dut_i (
    .clk(clk), .rst_n(rst_n), .hst_req(hst_req), .hst_we(hst_we),
    .hst_sel(hst_sel), .hst_off(hst_off), .hst_len(hst_len),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .hst_busy(hst_busy),
    .hst_done(hst_done), .probe_bus(probe_bus), .probe_devfn(probe_devfn),
    .dev_present(dev_present), .dn_valid(dn_valid), .dn_we(dn_we),
    .dn_bus(dn_bus), .dn_devfn(dn_devfn), .dn_reg(dn_reg), .dn_len(dn_len),
    .dn_wdata(dn_wdata), .dn_rvalid(dn_rvalid), .dn_rdata(dn_rdata)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic [1:0]  off;
    logic [2:0]  len;
    logic        we;
    logic        pres;
    logic        exp_dn;
    logic [7:0]  exp_reg;
    logic [2:0]  exp_len;
    logic [31:0] exp_rd;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{32'h8001_1004, 2'd0, 3'd4, 1'b0, 1'b1, 1'b1, 8'h04, 3'd4, 32'hC0DE_0404},
    '{32'h8002_0810, 2'd2, 3'd2, 1'b0, 1'b1, 1'b1, 8'h12, 3'd2, 32'hC0DE_1202},
    '{32'h8000_00FC, 2'd3, 3'd4, 1'b0, 1'b1, 1'b1, 8'hFF, 3'd1, 32'hC0DE_FF01},
    '{32'h8000_00FE, 2'd0, 3'd4, 1'b1, 1'b1, 1'b1, 8'hFE, 3'd2, 32'h0},
    '{32'h8000_00FD, 2'd1, 3'd2, 1'b0, 1'b1, 1'b1, 8'hFD, 3'd2, 32'hC0DE_FD02},
    '{32'h0003_0010, 2'd0, 3'd4, 1'b0, 1'b1, 1'b0, 8'h00, 3'd0, 32'hFFFF_FFFF},
    '{32'h0003_0010, 2'd1, 3'd1, 1'b0, 1'b1, 1'b0, 8'h00, 3'd0, 32'h0000_00FF},
    '{32'h0003_0010, 2'd0, 3'd4, 1'b1, 1'b1, 1'b0, 8'h00, 3'd0, 32'h0},
    '{32'h8007_0040, 2'd0, 3'd2, 1'b0, 1'b0, 1'b0, 8'h00, 3'd0, 32'h0000_FFFF},
    '{32'h8007_0040, 2'd0, 3'd4, 1'b1, 1'b0, 1'b0, 8'h00, 3'd0, 32'h0},
    '{32'h8005_0A20, 2'd1, 3'd1, 1'b1, 1'b1, 1'b1, 8'h21, 3'd1, 32'h0}
  };
  localparam string VTAG [NV] = '{"R3", "R6", "R7", "R7", "R6", "R5", "R5",
                                  "R4", "R8", "R8", "R9"};

  // results of the last access
  int          n_dn;
  int          busy_low;
  logic        got_done;
  logic [31:0] got_rd;
  logic        c_we;
  logic [7:0]  c_bus, c_devfn, c_reg;
  logic [2:0]  c_len;
  logic [31:0] c_wdata;

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic host_op(input logic we, input logic sel, input logic [1:0] off,
                         input logic [2:0] len, input logic [31:0] wd);
    int timer;
    n_dn = 0; busy_low = 0; got_done = 1'b0; got_rd = '0; timer = -1;
    @(negedge clk);
    hst_req = 1'b1; hst_we = we; hst_sel = sel; hst_off = off;
    hst_len = len; hst_wdata = wd;
    @(negedge clk);
    hst_req = 1'b0;
    for (int k = 0; k < 20; k++) begin
      dn_rvalid = 1'b0;
      if (hst_done) begin
        got_done = 1'b1;
        got_rd = hst_rdata;
        break;
      end
      if (!hst_busy) busy_low++;
      if (dn_valid) begin
        n_dn++;
        c_we = dn_we; c_bus = dn_bus; c_devfn = dn_devfn; c_reg = dn_reg;
        c_len = dn_len; c_wdata = dn_wdata;
        timer = 2;
      end else if (timer > 0) begin
        timer--;
        if (timer == 0) begin
          dn_rvalid = 1'b1;
          dn_rdata = 32'hC0DE_0000 | {16'h0, c_reg, 5'h0, c_len};
        end
      end
      @(negedge clk);
    end
    dn_rvalid = 1'b0;
  endtask

  initial begin
    #4_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "dn_valid in reset", {31'h0, dn_valid}, 32'h0);
    chk("R10", "hst_busy in reset", {31'h0, hst_busy}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "hst_done after reset", {31'h0, hst_done}, 32'h0);
    host_op(1'b0, 1'b0, 2'd0, 3'd4, 32'h0);
    chk("R10", "address register after reset", hst_rdata, 32'h0);
    host_op(1'b0, 1'b1, 2'd0, 3'd4, 32'h0);
    chk("R10", "data window disabled after reset", n_dn, 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      dev_present = 1'b1;
      host_op(1'b1, 1'b0, 2'd0, 3'd4, VEC[i].addr);
      host_op(1'b0, 1'b0, 2'd0, 3'd4, 32'h0);
      chk("R2", "address readback", hst_rdata, VEC[i].addr);
      chk("R3", "probe bus", {24'h0, probe_bus}, {24'h0, VEC[i].addr[23:16]});
      dev_present = VEC[i].pres;
      host_op(VEC[i].we, 1'b1, VEC[i].off, VEC[i].len, 32'h5A5A_0000 + i);
      chk(VTAG[i], "strobe count", n_dn, VEC[i].exp_dn ? 1 : 0);
      chk("R9", "completion seen", {31'h0, got_done}, 32'h1);
      if (VEC[i].exp_dn) begin
        chk("R9", "busy while waiting", busy_low, 0);
        chk("R3", "dn_bus", {24'h0, c_bus}, {24'h0, VEC[i].addr[23:16]});
        chk("R3", "dn_devfn", {24'h0, c_devfn}, {24'h0, VEC[i].addr[15:8]});
        chk(VTAG[i], "dn_reg", {24'h0, c_reg}, {24'h0, VEC[i].exp_reg});
        chk(VTAG[i], "dn_len", {29'h0, c_len}, {29'h0, VEC[i].exp_len});
        chk(VTAG[i], "dn_we", {31'h0, c_we}, {31'h0, VEC[i].we});
        if (VEC[i].we) chk(VTAG[i], "dn_wdata", c_wdata, 32'h5A5A_0000 + i);
      end
      if (!VEC[i].we) chk(VTAG[i], "read data", got_rd, VEC[i].exp_rd);
    end
    dev_present = 1'b1;

    // R1: writes that do not qualify are ignored
    host_op(1'b1, 1'b0, 2'd0, 3'd4, 32'h8009_0900);
    host_op(1'b1, 1'b0, 2'd1, 3'd4, 32'h1234_5678);
    host_op(1'b0, 1'b0, 2'd0, 3'd4, 32'h0);
    chk("R1", "offset-1 write ignored", hst_rdata, 32'h8009_0900);
    host_op(1'b1, 1'b0, 2'd0, 3'd2, 32'h0000_1111);
    host_op(1'b0, 1'b0, 2'd0, 3'd4, 32'h0);
    chk("R1", "two-byte write ignored", hst_rdata, 32'h8009_0900);
    host_op(1'b1, 1'b0, 2'd0, 3'd4, 32'h0000_0000);
    host_op(1'b0, 1'b0, 2'd0, 3'd4, 32'h0);
    chk("R1", "full write at offset 0 loads", hst_rdata, 32'h0);

    // R9: strobe timing and single-cycle width, checked edge by edge
    host_op(1'b1, 1'b0, 2'd0, 3'd4, 32'h800A_0B08);
    @(negedge clk);
    hst_req = 1'b1; hst_we = 1'b0; hst_sel = 1'b1; hst_off = 2'd0; hst_len = 3'd4;
    @(negedge clk);
    hst_req = 1'b0;
    chk("R9", "strobe one cycle after accept", {31'h0, dn_valid}, 32'h1);
    @(negedge clk);
    chk("R9", "strobe dropped next cycle", {31'h0, dn_valid}, 32'h0);
    chk("R9", "busy while waiting", {31'h0, hst_busy}, 32'h1);
    dn_rvalid = 1'b1; dn_rdata = 32'hBEEF_0001;
    @(negedge clk);
    dn_rvalid = 1'b0;
    chk("R9", "done after response", {31'h0, hst_done}, 32'h1);
    chk("R9", "response data returned", hst_rdata, 32'hBEEF_0001);
    @(negedge clk);
    chk("R9", "busy released", {31'h0, hst_busy}, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule